// File: doc/BRIEF.md
# Program-Counter-Sequenced Accumulator Datapath

This block is a very small teaching datapath. A 4-bit program counter steps through 16 locations. Its two most significant bits, in swapped order, form the operation code. No instruction memory is involved, so the counter value by itself selects one of four operations: hold, load the upper operand, load the lower operand, or add.

A 16-word data table sits inside the block and is set by a parameter. It is read combinationally at the address held in the counter. Two 4-bit operand registers capture words from this table. A 4-bit adder sums the two operands into a 5-bit accumulator, and the extra bit keeps the carry.

A step input advances the machine by one operation. A direct write port lets a controller place any value into the counter, which is how a chosen sequence of operations is driven.

Top module: `stepacc_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counter, both operand registers and the accumulator become zero.
- R2: When `pc_wr` is low and `step_en` is high, the counter increases by one on the clock edge and wraps from 15 to 0. When both `pc_wr` and `step_en` are low, the counter keeps its value.
- R3: When `pc_wr` is high, the counter takes `pc_wr_val` on the clock edge, whatever the value of `step_en`. On that same edge, any operation selected by `step_en` uses the counter value from before the write.
- R4: `op_q` equals {pc[2], pc[3]}. Counter values 0–3 give 00, 4–7 give 10, 8–11 give 01 and 12–15 give 11. The two low counter bits have no effect on `op_q`.
- R5: A step with opcode 01 loads `reg_hi` with table word [pc]. `reg_lo` and `acc_q` keep their values.
- R6: A step with opcode 10 loads `reg_lo` with table word [pc]. `reg_hi` and `acc_q` keep their values.
- R7: A step with opcode 11 loads `acc_q` with the 5-bit sum of `reg_hi` and `reg_lo`, bit 4 being the carry. With the default table, the sequence counter 8, then 4, then 12 gives upper 1000, lower 1110 and accumulator 10110.
- R8: A step with opcode 00 leaves both operand registers and the accumulator unchanged.
- R9: While `step_en` is low, neither operand register nor the accumulator changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Execute the current operation and advance the counter |
| pc_wr | input | 1 | Write strobe for the counter |
| pc_wr_val | input | 4 | Value written into the counter |
| pc_q | output | 4 | Current counter value |
| op_q | output | 2 | Opcode decoded from the counter |
| reg_hi | output | 4 | Upper operand register |
| reg_lo | output | 4 | Lower operand register |
| acc_q | output | 5 | Accumulator, carry in bit 4 |

## Verification
The bench builds the block with its default 4-bit widths and the default table contents. In the default table, word 8 is 1000 and word 4 is 1110, so the literal sequence 8, 4, 12 can be checked against the sum 10110. With the default widths, a free-running stretch of more than 16 steps passes through every counter value, crosses the 15-to-0 wrap and performs adds that carry. Direct writes place the counter on hold values whose low bits differ. Those writes are also applied in the same cycle as a step, which exercises the write priority.

// File: rtl/stepacc_pkg.sv
// Package: shared opcode type and decode helper for the accumulator datapath.
// Assumes the opcode is formed from the two top counter bits.
package stepacc_pkg;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'b00,
        OP_LD_HI  = 2'b01,
        OP_LD_LO  = 2'b10,
        OP_ADD    = 2'b11
    } op_e;

    // Swap the two top counter bits into an opcode.
    function automatic op_e op_from_top(input logic [1:0] top);
        return op_e'({top[0], top[1]});
    endfunction

endpackage

// File: rtl/stepacc_pc.sv
// Module: program counter with direct write and step increment.
// Assumes synchronous active-low reset; write has priority over stepping.
module stepacc_pc #(
    parameter int PC_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_en,
    input  logic            pc_wr,
    input  logic [PC_W-1:0] pc_wr_val,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

    logic [PC_W-1:0] pc_next;

    // Choose the next counter value: write, step, or hold.
    always_comb begin
        if (pc_wr)
            pc_next = pc_wr_val;
        else if (step_en)
            pc_next = pc + PC_ONE;
        else
            pc_next = pc;
    end

    // Counter register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else
            pc <= pc_next;
    end
endmodule

// File: rtl/stepacc_decode.sv
// Module: turns the top two counter bits into an opcode and load strobes.
// Assumes strobes act only on cycles where a step is requested.
module stepacc_decode
    import stepacc_pkg::*;
(
    input  logic [1:0] pc_top,
    input  logic       step_en,
    output op_e        op,
    output logic       ld_hi,
    output logic       ld_lo,
    output logic       ld_acc
);
    // Decode the opcode from the swapped top bits.
    always_comb op = op_from_top(pc_top);

    // Raise exactly one strobe for the active opcode during a step.
    always_comb begin
        ld_hi  = 1'b0;
        ld_lo  = 1'b0;
        ld_acc = 1'b0;
        if (step_en) begin
            unique case (op)
                OP_LD_HI: ld_hi  = 1'b1;
                OP_LD_LO: ld_lo  = 1'b1;
                OP_ADD:   ld_acc = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/stepacc_data.sv
// Module: data table, operand registers, adder and accumulator.
// Assumes the table is constant and read combinationally at the counter address.
module stepacc_data #(
    parameter int                     DATA_W   = 4,
    parameter int                     ADDR_W   = 4,
    parameter logic [(DATA_W<<ADDR_W)-1:0] MEM_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              ld_acc,
    output logic [DATA_W-1:0] hi_q,
    output logic [DATA_W-1:0] lo_q,
    output logic [DATA_W:0]   acc
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] table_w [DEPTH];
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W:0]   sum;

    // Unpack the parameter into one table word per address.
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign table_w[i] = MEM_INIT[i*DATA_W +: DATA_W];
    end

    // Read the word at the current counter address.
    always_comb rd_word = table_w[addr];

    // Add the operands, keeping the carry.
    always_comb sum = {1'b0, hi_q} + {1'b0, lo_q};

    // Upper operand register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_q <= '0;
        else if (ld_hi)
            hi_q <= rd_word;
    end

    // Lower operand register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= '0;
        else if (ld_lo)
            lo_q <= rd_word;
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (ld_acc)
            acc <= sum;
    end
endmodule

// File: rtl/stepacc_core.sv
// Module: top of the counter-sequenced accumulator datapath.
// Assumes the opcode is taken from the two top counter bits and no fetch stage.
module stepacc_core
    import stepacc_pkg::*;
#(
    parameter int                     DATA_W   = 4,
    parameter int                     PC_W     = 4,
    parameter logic [(DATA_W<<PC_W)-1:0] MEM_INIT = 64'h39C6_F1A8_427E_BD50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              pc_wr,
    input  logic [PC_W-1:0]   pc_wr_val,
    output logic [PC_W-1:0]   pc_q,
    output logic [1:0]        op_q,
    output logic [DATA_W-1:0] reg_hi,
    output logic [DATA_W-1:0] reg_lo,
    output logic [DATA_W:0]   acc_q
);
    op_e  op;
    logic ld_hi, ld_lo, ld_acc;

    stepacc_pc #(.PC_W(PC_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .pc_wr     (pc_wr),
        .pc_wr_val (pc_wr_val),
        .pc        (pc_q)
    );

    stepacc_decode u_dec (
        .pc_top  (pc_q[PC_W-1 -: 2]),
        .step_en (step_en),
        .op      (op),
        .ld_hi   (ld_hi),
        .ld_lo   (ld_lo),
        .ld_acc  (ld_acc)
    );

    stepacc_data #(.DATA_W(DATA_W), .ADDR_W(PC_W), .MEM_INIT(MEM_INIT)) u_data (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (pc_q),
        .ld_hi  (ld_hi),
        .ld_lo  (ld_lo),
        .ld_acc (ld_acc),
        .hi_q   (reg_hi),
        .lo_q   (reg_lo),
        .acc    (acc_q)
    );

    // Present the opcode as a plain vector.
    always_comb op_q = op;
endmodule

// File: rtl/stepacc_chk.sv
// Module: assertion checker for stepacc_core, attached by bind.
// Assumes default-style widths; observes ports only.
module stepacc_chk #(
    parameter int DATA_W = 4,
    parameter int PC_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_en,
    input logic              pc_wr,
    input logic [PC_W-1:0]   pc_wr_val,
    input logic [PC_W-1:0]   pc_q,
    input logic [1:0]        op_q,
    input logic [DATA_W-1:0] reg_hi,
    input logic [DATA_W-1:0] reg_lo,
    input logic [DATA_W:0]   acc_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && reg_hi == '0 && reg_lo == '0 && acc_q == '0));

    // R2
    pc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !pc_wr && pc_q == {PC_W{1'b1}}) |=> pc_q == '0);

    // R3
    pc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr |=> pc_q == $past(pc_wr_val));

    // R5
    load_hi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && op_q == 2'b01) |=> ($stable(reg_lo) && $stable(acc_q)));

    // R6
    load_lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && op_q == 2'b10) |=> ($stable(reg_hi) && $stable(acc_q)));

    // R7
    add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && op_q == 2'b11) |=>
            acc_q == ({1'b0, $past(reg_hi)} + {1'b0, $past(reg_lo)}));

    // R8
    hold_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && op_q == 2'b00) |=>
            ($stable(reg_hi) && $stable(reg_lo) && $stable(acc_q)));

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(reg_hi) && $stable(reg_lo) && $stable(acc_q)));
endmodule

bind stepacc_core stepacc_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (.*);

// File: tb/stepacc_core_test.sv
// Bench: behavioural reference model compared with the datapath on every clock.
module stepacc_core_test;
    localparam logic [63:0] TABLE = 64'h39C6_F1A8_427E_BD50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_en = 1'b0;
    logic       pc_wr = 1'b0;
    logic [3:0] pc_wr_val = '0;
    logic [3:0] pc_q;
    logic [1:0] op_q;
    logic [3:0] reg_hi, reg_lo;
    logic [4:0] acc_q;

    int checks = 0;
    int errors = 0;
    int m_pc = 0, m_hi = 0, m_lo = 0, m_acc = 0;
    bit done = 0;

    stepacc_core #(.MEM_INIT(TABLE)) uut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .pc_wr(pc_wr),
        .pc_wr_val(pc_wr_val), .pc_q(pc_q), .op_q(op_q),
        .reg_hi(reg_hi), .reg_lo(reg_lo), .acc_q(acc_q)
    );

    always #5 clk = ~clk;

    function automatic int word_at(int a);
        return int'((TABLE >> (a * 4)) & 64'hF);
    endfunction

    function automatic int op_of(int p);
        case (p / 4)
            0: return 0;
            1: return 2;
            2: return 1;
            default: return 3;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check({tag, " pc"}, int'(pc_q), m_pc);
        check({tag, " op (R4)"}, int'(op_q), op_of(m_pc));
        check({tag, " hi"}, int'(reg_hi), m_hi);
        check({tag, " lo"}, int'(reg_lo), m_lo);
        check({tag, " acc"}, int'(acc_q), m_acc);
    endtask

    // One clock: drive at the falling edge, update the model at the rise, compare after.
    task automatic cyc(bit rn, bit en, bit wr, int val, string tag);
        int op;
        @(negedge clk);
        rst_n = rn; step_en = en; pc_wr = wr; pc_wr_val = 4'(val);
        @(posedge clk);
        if (!rn) begin
            m_pc = 0; m_hi = 0; m_lo = 0; m_acc = 0;
        end else begin
            op = op_of(m_pc);
            if (en) begin
                if (op == 1) m_hi = word_at(m_pc);
                else if (op == 2) m_lo = word_at(m_pc);
                else if (op == 3) m_acc = m_hi + m_lo;
            end
            if (wr) m_pc = val;
            else if (en) m_pc = (m_pc + 1) % 16;
        end
        #1;
        compare_all(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset with stepping requested
        cyc(0, 1, 1, 9, "R1 reset");
        cyc(0, 1, 0, 0, "R1 reset");
        check("R1 pc zero", int'(pc_q), 0);
        check("R1 acc zero", int'(acc_q), 0);
        // R9 / R2: idle cycles keep everything
        cyc(1, 0, 0, 0, "R9 idle");
        cyc(1, 0, 0, 0, "R2 hold");
        // Reference sequence
        cyc(1, 0, 1, 8, "R3 write 1000");
        check("R4 op at 1000", int'(op_q), 1);
        cyc(1, 1, 0, 0, "R5 load upper");
        check("R5 upper=1000", int'(reg_hi), 8);
        cyc(1, 0, 1, 4, "R3 write 0100");
        check("R4 op at 0100", int'(op_q), 2);
        cyc(1, 1, 0, 0, "R6 load lower");
        check("R6 lower=1110", int'(reg_lo), 14);
        cyc(1, 0, 1, 12, "R3 write 1100");
        check("R4 op at 1100", int'(op_q), 3);
        cyc(1, 1, 0, 0, "R7 add");
        check("R7 acc=10110", int'(acc_q), 22);
        // R8: hold opcode at two low-bit patterns
        cyc(1, 0, 1, 0, "R3 write 0000");
        cyc(1, 1, 0, 0, "R8 hold 0000");
        check("R8 acc kept", int'(acc_q), 22);
        cyc(1, 0, 1, 3, "R3 write 0011");
        cyc(1, 1, 0, 0, "R8 hold 0011");
        check("R8 upper kept", int'(reg_hi), 8);
        // R4: low bits ignored
        cyc(1, 0, 1, 7, "R3 write 0111");
        check("R4 op at 0111", int'(op_q), 2);
        // R3: write and step together
        cyc(1, 1, 1, 13, "R3 write+step");
        check("R3 pc=13", int'(pc_q), 13);
        check("R6 lower from word 7", int'(reg_lo), word_at(7));
        // R2: free run through wrap and all opcodes
        for (int i = 0; i < 40; i++) cyc(1, 1, 0, 0, "R2 run");
        check("R2 wrap position", int'(pc_q), (13 + 40) % 16);
        // R9 idle after activity
        cyc(1, 0, 0, 0, "R9 idle after run");
        // R1 reset mid-run
        cyc(0, 1, 0, 0, "R1 mid reset");
        check("R1 hi zero", int'(reg_hi), 0);
        check("R1 lo zero", int'(reg_lo), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule